// File: doc/BRIEF.md
# Configuration Change Protection Unit

This block keeps a handful of sensitive control registers from being changed by a stray store. Before software may update a guarded bit, it must write a fixed unlock value to a key register. That write opens a short unlock window, counted in instruction cycles, and guarded writes are accepted only while the window is open. The window closes by itself. While it is open, interrupt requests from the core are held off, so that an interrupt handler cannot run in the middle of an unlock sequence.

The unit sits on a register-file style bus with address, write strobe, write data and read strobe. An instruction-cycle strobe from the core advances the window count, so an instruction that takes several clocks counts once. The four guarded registers are held as storage inside the block. Each register has a bit mask that says which of its bits need the unlock; the other bits can be written at any time. The block gives out per-register write strobes, the read data, an interrupt-suppress flag and the request that is passed on to the core.

Top module: `regkey_lock`

## Requirements
- R1: After reset (asynchronous, active low) the key register and all four guarded registers read 0x00, the window is closed, and `irq_block` is low.
- R2: A write of 0xD8 to the key register at address 0x3C opens the window from the next clock edge on. While the window is open, the key register reads 0x01.
- R3: The window stays open for exactly four `insn_tick` pulses that come after the unlocking write, and closes at the clock edge of the fourth pulse. A tick in the same cycle as the unlocking write is not counted. Clocks without a tick do not advance the count.
- R4: A write of any value other than 0xD8 to the key register does not open the window, and does not reload a window that is already open; the count continues.
- R5: A write of 0xD8 while the window is open restarts the count at four ticks.
- R6: While the window is closed, guarded bits ignore writes and the unguarded bits in the same write still update. The guarded masks are: 0x36 clock select 0xFF, 0x37 clock prescale 0xFF, 0x31 watchdog control 0x2F (enable bit 5, prescaler bits 3:0), 0x3A core control 0x10 (brown-out disable bit 4).
- R7: While the window is open, every bit of a guarded register takes the written value. Such a write does not close the window early.
- R8: `irq_block` is high exactly while the window is open. `irq_fwd` equals `irq_req` when the window is closed and is low when it is open.
- R9: `reg_we[i]` is high, combinationally, in a cycle with `bus_wr` high and `bus_addr` equal to the address of guarded register i (index 0..3 = 0x36, 0x37, 0x31, 0x3A). At most one bit is set.
- R10: Bits 7:1 of the key register always read 0. A read of an address outside the block's map returns 0x00. `rd_data` is 0x00 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| insn_tick | input | 1 | One pulse per completed instruction cycle |
| irq_req | input | 1 | Interrupt request from the core |
| rd_data | output | 8 | Read data, combinational |
| reg_we | output | 4 | Per guarded register write strobe |
| irq_block | output | 1 | Interrupt suppress, high while unlocked |
| irq_fwd | output | 1 | Interrupt request passed on to the core |

## Verification
A wrong window count is visible at once on `irq_block` and on bit 0 of the key register. A count that runs short or long shows up as a flag that drops one tick early or stays high one tick late. The bench therefore reads the key register after every single tick of a window, including windows that were restarted, or fed non-key writes, or ticked in the same cycle as the unlock. A wrong mask or a wrong unlock qualification remains hidden in storage until the register is read back. Each guarded write is therefore followed in the next cycle by a read of the same register, which exposes a dropped or leaked bit one clock after the write.

// File: rtl/regkey_pkg.sv
package regkey_pkg;
  localparam int DW      = 8;
  localparam int AW      = 6;
  localparam int NREG    = 4;
  localparam int WIN_LEN = 4;

  localparam logic [AW-1:0] KEY_ADDR = 6'h3C;
  localparam logic [DW-1:0] KEY_VAL  = 8'hD8;

  // index 0: clock select, 1: clock prescale, 2: watchdog control, 3: core control
  localparam logic [NREG-1:0][AW-1:0] REG_ADDR = {6'h3A, 6'h31, 6'h37, 6'h36};
  localparam logic [NREG-1:0][DW-1:0] REG_MASK = {8'h10, 8'h2F, 8'hFF, 8'hFF};
endpackage

// File: rtl/regkey_window.sv
module regkey_window #(
  parameter int DW      = 8,
  parameter int WIN_LEN = 4,
  parameter logic [DW-1:0] KEY_VAL = 8'hD8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  input  logic          insn_tick,
  output logic          open_o
);
  localparam int CW = $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sig_hit;
  logic          cnt_en;

  assign sig_hit = key_wr && (key_data == KEY_VAL);
  assign open_o  = (cnt_q != '0);

  // next state: a signature reloads, a tick drains an open window
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (sig_hit) begin
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (insn_tick && open_o) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/regkey_cell.sv
module regkey_cell #(
  parameter int DW = 8,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          unlocked,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;
  logic [DW-1:0] take;

  // bits that accept the write: all when unlocked, only unguarded otherwise
  always_comb begin
    take = unlocked ? {DW{1'b1}} : ~MASK;
    q_d  = (q & ~take) | (wdata & take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/regkey_rdmux.sv
module regkey_rdmux #(
  parameter int DW   = 8,
  parameter int AW   = 6,
  parameter int NREG = 4,
  parameter logic [AW-1:0] KEY_ADDR = 6'h3C,
  parameter logic [NREG-1:0][AW-1:0] REG_ADDR = '0
) (
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic                     open_i,
  input  logic [NREG-1:0][DW-1:0]  regs,
  output logic [DW-1:0]            rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == KEY_ADDR) begin
        rd_data = {{(DW-1){1'b0}}, open_i};
      end
      for (int i = 0; i < NREG; i++) begin
        if (addr == REG_ADDR[i]) begin
          rd_data = regs[i];
        end
      end
    end
  end
endmodule

// File: rtl/regkey_lock.sv
module regkey_lock
  import regkey_pkg::*;
#(
  parameter int P_DW      = regkey_pkg::DW,
  parameter int P_AW      = regkey_pkg::AW,
  parameter int P_NREG    = regkey_pkg::NREG,
  parameter int P_WIN_LEN = regkey_pkg::WIN_LEN,
  parameter logic [P_AW-1:0] P_KEY_ADDR = regkey_pkg::KEY_ADDR,
  parameter logic [P_DW-1:0] P_KEY_VAL  = regkey_pkg::KEY_VAL,
  parameter logic [P_NREG-1:0][P_AW-1:0] P_REG_ADDR = regkey_pkg::REG_ADDR,
  parameter logic [P_NREG-1:0][P_DW-1:0] P_REG_MASK = regkey_pkg::REG_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P_AW-1:0]   bus_addr,
  input  logic              bus_wr,
  input  logic [P_DW-1:0]   bus_wdata,
  input  logic              bus_rd,
  input  logic              insn_tick,
  input  logic              irq_req,
  output logic [P_DW-1:0]   rd_data,
  output logic [P_NREG-1:0] reg_we,
  output logic              irq_block,
  output logic              irq_fwd
);
  logic                          key_wr;
  logic                          win_open;
  logic [P_NREG-1:0][P_DW-1:0]   reg_q;

  assign key_wr = bus_wr && (bus_addr == P_KEY_ADDR);

  regkey_window #(
    .DW      (P_DW),
    .WIN_LEN (P_WIN_LEN),
    .KEY_VAL (P_KEY_VAL)
  ) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .key_data  (bus_wdata),
    .insn_tick (insn_tick),
    .open_o    (win_open)
  );

  for (genvar g = 0; g < P_NREG; g++) begin : g_reg
    assign reg_we[g] = bus_wr && (bus_addr == P_REG_ADDR[g]);

    regkey_cell #(
      .DW   (P_DW),
      .MASK (P_REG_MASK[g])
    ) cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we[g]),
      .unlocked (win_open),
      .wdata    (bus_wdata),
      .q        (reg_q[g])
    );
  end

  regkey_rdmux #(
    .DW       (P_DW),
    .AW       (P_AW),
    .NREG     (P_NREG),
    .KEY_ADDR (P_KEY_ADDR),
    .REG_ADDR (P_REG_ADDR)
  ) rd_i (
    .rd_en   (bus_rd),
    .addr    (bus_addr),
    .open_i  (win_open),
    .regs    (reg_q),
    .rd_data (rd_data)
  );

  assign irq_block = win_open;
  assign irq_fwd   = irq_req && !win_open;
endmodule

// File: rtl/regkey_lock_chk.sv
module regkey_lock_chk
  import regkey_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_rd,
  input logic          insn_tick,
  input logic          irq_req,
  input logic [DW-1:0] rd_data,
  input logic [NREG-1:0] reg_we,
  input logic          irq_block,
  input logic          irq_fwd
);
  logic key_sig, key_other;
  assign key_sig   = bus_wr && (bus_addr == KEY_ADDR) && (bus_wdata == KEY_VAL);
  assign key_other = bus_wr && (bus_addr == KEY_ADDR) && (bus_wdata != KEY_VAL);

  assert_unlock_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_sig |=> irq_block);

  assert_bad_key_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_other && !irq_block) |=> !irq_block);

  assert_no_self_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_block && !key_sig) |=> !irq_block);

  assert_no_close_without_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_block && !insn_tick) |=> irq_block);

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_block |-> !irq_fwd);

  assert_irq_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_block && irq_req) |-> irq_fwd);

  assert_we_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we));

  assert_key_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == KEY_ADDR) |-> (rd_data == {{(DW-1){1'b0}}, irq_block}));

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (rd_data == '0));
endmodule

bind regkey_lock regkey_lock_chk chk_i (.*);

// File: tb/regkey_lock_tb.sv
module regkey_lock_tb_top;
  import regkey_pkg::*;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rd;
  logic          insn_tick;
  logic          irq_req;
  logic [DW-1:0] rd_data;
  logic [NREG-1:0] reg_we;
  logic          irq_block;
  logic          irq_fwd;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  regkey_lock dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .insn_tick(insn_tick),
    .irq_req(irq_req), .rd_data(rd_data), .reg_we(reg_we),
    .irq_block(irq_block), .irq_fwd(irq_fwd)
  );

  typedef struct packed {
    logic          wr;
    logic [5:0]    addr;
    logic [7:0]    data;
    logic          tick;
    logic [5:0]    raddr;
    logic [7:0]    exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h00, 8'h00, 1'b0, 6'h3C, 8'h00, 4'd1},  // R1 key idle
    '{1'b1, 6'h31, 8'hFF, 1'b0, 6'h31, 8'hD0, 4'd6},  // R6 watchdog locked
    '{1'b1, 6'h3A, 8'hFF, 1'b0, 6'h3A, 8'hEF, 4'd6},  // R6 core ctrl locked
    '{1'b1, 6'h36, 8'h05, 1'b0, 6'h36, 8'h00, 4'd6},  // R6 clock select locked
    '{1'b1, 6'h3C, 8'h55, 1'b0, 6'h3C, 8'h00, 4'd4},  // R4 wrong key
    '{1'b1, 6'h3C, 8'hD8, 1'b0, 6'h3C, 8'h01, 4'd2},  // R2 unlock
    '{1'b1, 6'h36, 8'h05, 1'b0, 6'h36, 8'h05, 4'd7},  // R7 write inside window
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd3},  // R3 tick 1
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd3},  // R3 tick 2
    '{1'b1, 6'h3C, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd4},  // R4 no reload, tick 3
    '{1'b1, 6'h31, 8'hFF, 1'b1, 6'h31, 8'hFF, 4'd7},  // R7 last open tick
    '{1'b0, 6'h00, 8'h00, 1'b0, 6'h3C, 8'h00, 4'd3},  // R3 closed after four
    '{1'b1, 6'h31, 8'h00, 1'b0, 6'h31, 8'h2F, 4'd6},  // R6 guarded bits kept
    '{1'b1, 6'h3C, 8'hD8, 1'b0, 6'h3C, 8'h01, 4'd2},  // R2 unlock again
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd3},  // R3
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd3},  // R3
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd3},  // R3 one tick left
    '{1'b1, 6'h3C, 8'hD8, 1'b0, 6'h3C, 8'h01, 4'd5},  // R5 restart
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd5},  // R5 would have closed
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd5},  // R5
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h01, 4'd5},  // R5
    '{1'b0, 6'h00, 8'h00, 1'b1, 6'h3C, 8'h00, 4'd5},  // R5 closes on fourth
    '{1'b1, 6'h37, 8'h03, 1'b0, 6'h37, 8'h00, 4'd6},  // R6 prescale locked
    '{1'b0, 6'h00, 8'h00, 1'b0, 6'h20, 8'h00, 4'd10}  // R10 unmapped
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [5:0] a, input logic [7:0] d, input logic t);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; insn_tick = t; bus_rd = 1'b0;
    @(posedge clk);
    #2;
    bus_wr = 1'b0; insn_tick = 1'b0;
  endtask

  task automatic rd_check(input logic [5:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    check(tag, rd_data, exp);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; insn_tick = 1'b0; irq_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #2;
    check("R1 irq_block after reset", {7'b0, irq_block}, 8'h00);
    for (int i = 0; i < NREG; i++) begin
      rd_check(REG_ADDR[i], 8'h00, $sformatf("R1 reg %0d after reset", i));
    end

    // vector table
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].tick);
      rd_check(VECS[i].raddr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R10 idle read gives zero even at a populated address
    #2;
    bus_addr = 6'h31; bus_rd = 1'b0; #2;
    check("R10 rd_data with bus_rd low", rd_data, 8'h00);

    // R9 per-register write strobes
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h37; bus_wdata = 8'h00; #2;
    check("R9 strobe prescale", {4'b0, reg_we}, 8'h02);
    bus_addr = 6'h31; bus_wdata = 8'h2F; #2;
    check("R9 strobe watchdog", {4'b0, reg_we}, 8'h04);
    bus_addr = 6'h3A; bus_wdata = 8'hEF; #2;
    check("R9 strobe core ctrl", {4'b0, reg_we}, 8'h08);
    bus_addr = 6'h3C; bus_wdata = 8'h00; #2;
    check("R9 no strobe on key", {4'b0, reg_we}, 8'h00);
    bus_wr = 1'b0; #2;
    check("R9 no strobe when idle", {4'b0, reg_we}, 8'h00);

    // R3 a tick in the unlock cycle does not count
    step(1'b1, 6'h3C, 8'hD8, 1'b1);
    rd_check(6'h3C, 8'h01, "R3 open after unlock with tick");
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 6'h00, 8'h00, 1'b1);
      rd_check(6'h3C, 8'h01, $sformatf("R3 open after tick %0d", k + 1));
    end
    step(1'b0, 6'h00, 8'h00, 1'b1);
    rd_check(6'h3C, 8'h00, "R3 closed after tick 4");

    // R3 idle clocks without tick keep the window
    step(1'b1, 6'h3C, 8'hD8, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b0, 6'h00, 8'h00, 1'b0);
    rd_check(6'h3C, 8'h01, "R3 clocks without tick");

    // R8 interrupt suppression
    irq_req = 1'b1; #1;
    check("R8 irq_block while open", {7'b0, irq_block}, 8'h01);
    check("R8 irq_fwd held while open", {7'b0, irq_fwd}, 8'h00);
    for (int k = 0; k < 4; k++) step(1'b0, 6'h00, 8'h00, 1'b1);
    check("R8 irq_block after close", {7'b0, irq_block}, 8'h00);
    check("R8 irq_fwd passes after close", {7'b0, irq_fwd}, 8'h01);
    irq_req = 1'b0;

    // R1 reset in the middle of an open window
    step(1'b1, 6'h3C, 8'hD8, 1'b0);
    @(negedge clk);
    rst_n = 1'b0; #2;
    check("R1 irq_block during reset", {7'b0, irq_block}, 8'h00);
    rd_check(6'h3C, 8'h00, "R1 key during reset");
    rd_check(6'h36, 8'h00, "R1 clock select during reset");
    rd_check(6'h31, 8'h00, "R1 watchdog during reset");
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    rd_check(6'h3C, 8'h00, "R1 key after reset release");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule